// File: doc/BRIEF.md
# Paged Register Access with Password Protection

This block serves byte reads and writes on an 8-bit address. Addresses 00h to 7Fh always reach a lower page. Addresses 80h to FFh reach one of several upper tables. The table is picked by a select byte that lives in the lower page. A layout bit, stored in the configuration table, renumbers two of the tables so that software written for an alternate numbering still finds them.

Access is guarded by two password levels, user and vendor. Software writes a 32-bit candidate into four volatile entry bytes. The block compares the candidate with the stored vendor password and the stored user password. Each level owns a read-protect byte and a write-protect byte, one bit per memory block. A set bit means the block needs that level or a higher one. A denied read returns zero, and a denied write is dropped. The serial front end and non-volatile backing are not part of this block; the storage is a plain register array that clears on reset.

Top module: `paged_guard`

## Requirements
- R1: After reset `rvalid_o` is low, `rdata_o` is 00h and every stored byte is 00h. So the select byte is 0, the layout bit is 0, and the vendor level is granted, because the entry bytes (00h) equal the stored vendor password (00h).
- R2: A read request returns its data with `rvalid_o` high in the cycle after the request, and `rvalid_o` is low after any cycle without a read. A permitted write updates the addressed byte at the request edge.
- R3: Addresses 80h–FFh reach physical table `sel` (the byte at 7Fh), offset `addr-80h`. A select value that names no table (6 or more with the default of six tables) gives read data 00h and ignores writes.
- R4: Addresses 00h–7Fh reach the lower page whatever value the select byte holds.
- R5: The following bytes always read 00h: the entry bytes 7Bh–7Eh; the vendor settings at F0h–F5h of table 4 (F0h read-protect, F1h write-protect, F2h–F5h password); and the user settings at E0h–E5h of table 5 (same order).
- R6: When bit 0 of byte 80h of physical table 4 is 1, select value 00h reaches table 1, select value 01h reaches table 4, and select value 04h names no table.
- R7: The granted level is vendor if the entry bytes {7Bh,7Ch,7Dh,7Eh} equal the vendor password {F2h..F5h}. Otherwise it is user if they equal the user password {E2h..E5h}. Otherwise it is none. Vendor may read and write every valid address.
- R8: Lower addresses 00h–77h form block 0, and physical table t forms block t+1. Bit b of a protect byte set to 1 means block b needs that byte's level or higher for that kind of access.
- R9: Addresses 78h–7Fh are readable and writable at every level.
- R10: A denied read returns 00h with `rvalid_o` high, and a denied write leaves the stored byte unchanged.
- R11: A write to an entry byte changes the granted level for the very next request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request strobe |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 8 | Write data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rdata_o | output | 8 | Read data |

## Verification
Two functions meet at a single edge. A write to an entry byte changes the granted level, and the request right behind it is judged against that new level. The bench provokes this by issuing a protected read in the cycle right after the candidate password is written. The scoreboard expects the unlocked data, because any lag in the level would return zero instead. Separately, writes that the protection refuses are checked later at a higher level: reading the address back shows that the earlier write left no trace.

// File: rtl/paged_guard_pkg.sv
`timescale 1ns/1ps
package paged_guard_pkg;
  typedef enum logic [1:0] {LVL_NONE = 2'd0, LVL_USER = 2'd1, LVL_VEND = 2'd2} lvl_e;
  localparam int PAGE_SZ  = 128;
  localparam int OFS_W    = 7;
  localparam int NUM_BLK  = 8;
  localparam int BLK_W    = 3;
  localparam int SET_LEN  = 6;  // rd-protect, wr-protect, 4 password bytes
endpackage

// File: rtl/pg_addr_map.sv
`timescale 1ns/1ps
module pg_addr_map
  import paged_guard_pkg::*;
#(
  parameter int NUM_TBL     = 6,
  parameter int RGN_W       = 3,
  parameter int CFG_TBL     = 4,
  parameter int USR_TBL     = 1,
  parameter int UPW_TBL     = 5,
  parameter int ALT_USR_NUM = 0,
  parameter int ALT_CFG_NUM = 1,
  parameter int VSET_OFS    = 'h70,
  parameter int USET_OFS    = 'h60,
  parameter logic [(NUM_TBL+1)*BLK_W-1:0] BLK_MAP = 21'o6543210
) (
  input  logic [7:0]       addr_i,
  input  logic [7:0]       sel_i,
  input  logic             alt_i,
  output logic [RGN_W-1:0] rgn_o,
  output logic [OFS_W-1:0] ofs_o,
  output logic             ok_o,
  output logic [BLK_W-1:0] blk_o,
  output logic             win_o,
  output logic             wo_o
);
  logic [7:0] phys;
  logic       upper, tbl_ok;
  logic [7:0] ofs8;

  always_comb begin
    phys = sel_i;
    if (alt_i) begin
      if (sel_i == 8'(ALT_USR_NUM))      phys = 8'(USR_TBL);
      else if (sel_i == 8'(ALT_CFG_NUM)) phys = 8'(CFG_TBL);
      else if (sel_i == 8'(CFG_TBL))     phys = 8'hFF;
    end
  end

  assign upper  = addr_i[7];
  assign tbl_ok = (phys < 8'(NUM_TBL));
  assign ofs_o  = addr_i[OFS_W-1:0];
  assign ofs8   = {1'b0, addr_i[OFS_W-1:0]};
  assign ok_o   = !upper || tbl_ok;
  assign rgn_o  = (upper && tbl_ok) ? RGN_W'(phys + 8'd1) : '0;
  assign blk_o  = BLK_MAP[rgn_o*BLK_W +: BLK_W];
  assign win_o  = (addr_i[7:3] == 5'b01111);

  always_comb begin
    wo_o = 1'b0;
    if (!upper)
      wo_o = (addr_i >= 8'h7B) && (addr_i <= 8'h7E);
    else if (tbl_ok && phys == 8'(CFG_TBL))
      wo_o = (ofs8 >= 8'(VSET_OFS)) && (ofs8 < 8'(VSET_OFS + SET_LEN));
    else if (tbl_ok && phys == 8'(UPW_TBL))
      wo_o = (ofs8 >= 8'(USET_OFS)) && (ofs8 < 8'(USET_OFS + SET_LEN));
  end
endmodule

// File: rtl/pg_access_ctl.sv
`timescale 1ns/1ps
module pg_access_ctl
  import paged_guard_pkg::*;
(
  input  logic [31:0]        entry_i,
  input  logic [31:0]        vpw_i,
  input  logic [31:0]        upw_i,
  input  logic [NUM_BLK-1:0] v_rd_i,
  input  logic [NUM_BLK-1:0] v_wr_i,
  input  logic [NUM_BLK-1:0] u_rd_i,
  input  logic [NUM_BLK-1:0] u_wr_i,
  input  logic [BLK_W-1:0]   blk_i,
  input  logic               ok_i,
  input  logic               win_i,
  output lvl_e               lvl_o,
  output logic               rd_ok_o,
  output logic               wr_ok_o
);
  always_comb begin
    if (entry_i == vpw_i)      lvl_o = LVL_VEND;
    else if (entry_i == upw_i) lvl_o = LVL_USER;
    else                       lvl_o = LVL_NONE;
  end

  function automatic logic grant(lvl_e l, logic need_v, logic need_u);
    return (l == LVL_VEND) || (!need_v && ((l == LVL_USER) || !need_u));
  endfunction

  assign rd_ok_o = ok_i && (win_i || grant(lvl_o, v_rd_i[blk_i], u_rd_i[blk_i]));
  assign wr_ok_o = ok_i && (win_i || grant(lvl_o, v_wr_i[blk_i], u_wr_i[blk_i]));
endmodule

// File: rtl/paged_guard.sv
`timescale 1ns/1ps
module paged_guard
  import paged_guard_pkg::*;
#(
  parameter int NUM_TBL   = 6,
  parameter int CFG_TBL   = 4,
  parameter int USR_TBL   = 1,
  parameter int UPW_TBL   = 5,
  parameter int ALT_USR   = 0,
  parameter int ALT_CFG   = 1,
  parameter int ALT_OFS   = 'h00,
  parameter int ALT_BIT   = 0,
  parameter int VSET_OFS  = 'h70,
  parameter int USET_OFS  = 'h60,
  parameter logic [(NUM_TBL+1)*BLK_W-1:0] BLK_MAP = 21'o6543210
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic       rvalid_o,
  output logic [7:0] rdata_o
);
  localparam int NUM_RGN = NUM_TBL + 1;
  localparam int RGN_W   = $clog2(NUM_RGN);
  localparam int IDX_W   = RGN_W + OFS_W;
  localparam int DEPTH   = NUM_RGN * PAGE_SZ;
  localparam int SEL_IX  = 'h7F;
  localparam int ENT_IX  = 'h7B;
  localparam int ALT_IX  = (CFG_TBL + 1) * PAGE_SZ + ALT_OFS;
  localparam int VSET_IX = (CFG_TBL + 1) * PAGE_SZ + VSET_OFS;
  localparam int USET_IX = (UPW_TBL + 1) * PAGE_SZ + USET_OFS;

  logic [7:0] mem [DEPTH];

  logic [RGN_W-1:0] rgn;
  logic [OFS_W-1:0] ofs;
  logic [IDX_W-1:0] idx;
  logic [BLK_W-1:0] blk;
  logic             map_ok, win, wo_hit, rd_ok, wr_ok;
  lvl_e             lvl;
  logic [31:0]      entry_pw, vend_pw, user_pw;

  assign entry_pw = {mem[ENT_IX], mem[ENT_IX+1], mem[ENT_IX+2], mem[ENT_IX+3]};
  assign vend_pw  = {mem[VSET_IX+2], mem[VSET_IX+3], mem[VSET_IX+4], mem[VSET_IX+5]};
  assign user_pw  = {mem[USET_IX+2], mem[USET_IX+3], mem[USET_IX+4], mem[USET_IX+5]};

  pg_addr_map #(
    .NUM_TBL(NUM_TBL), .RGN_W(RGN_W), .CFG_TBL(CFG_TBL), .USR_TBL(USR_TBL),
    .UPW_TBL(UPW_TBL), .ALT_USR_NUM(ALT_USR), .ALT_CFG_NUM(ALT_CFG),
    .VSET_OFS(VSET_OFS), .USET_OFS(USET_OFS), .BLK_MAP(BLK_MAP)
  ) u_map (
    .addr_i (addr_i),
    .sel_i  (mem[SEL_IX]),
    .alt_i  (mem[ALT_IX][ALT_BIT]),
    .rgn_o  (rgn),
    .ofs_o  (ofs),
    .ok_o   (map_ok),
    .blk_o  (blk),
    .win_o  (win),
    .wo_o   (wo_hit)
  );

  pg_access_ctl u_acc (
    .entry_i (entry_pw),
    .vpw_i   (vend_pw),
    .upw_i   (user_pw),
    .v_rd_i  (mem[VSET_IX]),
    .v_wr_i  (mem[VSET_IX+1]),
    .u_rd_i  (mem[USET_IX]),
    .u_wr_i  (mem[USET_IX+1]),
    .blk_i   (blk),
    .ok_i    (map_ok),
    .win_i   (win),
    .lvl_o   (lvl),
    .rd_ok_o (rd_ok),
    .wr_ok_o (wr_ok)
  );

  assign idx = {rgn, ofs};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= req_i && !we_i;
      if (req_i && !we_i)
        rdata_o <= (rd_ok && !wo_hit) ? mem[idx] : 8'h00;
      if (req_i && we_i && wr_ok)
        mem[idx] <= wdata_i;
    end
  end
endmodule

// File: rtl/paged_guard_chk.sv
`timescale 1ns/1ps
module paged_guard_chk
  import paged_guard_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       we_i,
  input logic [7:0] addr_i,
  input logic       rvalid_o,
  input logic [7:0] rdata_o,
  input logic       rd_ok,
  input logic       wr_ok,
  input logic       wo_hit,
  input logic       map_ok,
  input lvl_e       lvl
);
  // R2
  rd_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  // R2
  no_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);
  // R10
  deny_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !rd_ok) |=> (rdata_o == 8'h00));
  // R5
  wo_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && wo_hit) |=> (rdata_o == 8'h00));
  // R9
  win_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[7:3] == 5'b01111) |-> (rd_ok && wr_ok));
  // R7
  vend_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl == LVL_VEND && map_ok) |-> (rd_ok && wr_ok));
endmodule

bind paged_guard paged_guard_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rvalid_o(rvalid_o),
  .rdata_o (rdata_o),
  .rd_ok   (rd_ok),
  .wr_ok   (wr_ok),
  .wo_hit  (wo_hit),
  .map_ok  (map_ok),
  .lvl     (lvl)
);

// File: tb/paged_guard_bench.sv
`timescale 1ns/1ps
module paged_guard_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic       rvalid;
  logic [7:0] rdata;

  int n_tot = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  paged_guard u_paged_guard (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected rvalid", 8'h01, 8'h00);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    check("watchdog", 8'h00, 8'h01);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rvalid", {7'd0, rvalid}, 8'h00);
    check("R1 rdata", rdata, 8'h00);
    rd(8'h00, 8'h00, "R1 lower");
    rd(8'h7F, 8'h00, "R1 select");
    rd(8'h80, 8'h00, "R1 table0");
    // basic write/read
    wr(8'h10, 8'hA5); rd(8'h10, 8'hA5, "R2 readback");
    wr(8'h7F, 8'h02); wr(8'h85, 8'h3C);
    rd(8'h85, 8'h3C, "R3 table2");
    rd(8'h10, 8'hA5, "R4 lower under sel2");
    rd(8'h7F, 8'h02, "R4 select byte");
    wr(8'h7F, 8'h00); rd(8'h85, 8'h00, "R3 table0 distinct");
    wr(8'h7F, 8'h07); wr(8'h85, 8'h77);
    rd(8'h85, 8'h00, "R3 bad select read");
    wr(8'h7F, 8'h02); rd(8'h85, 8'h3C, "R3 bad select write ignored");
    // write-only bytes; level becomes none after entry change
    wr(8'h7B, 8'h11); rd(8'h7B, 8'h00, "R5 entry");
    wr(8'h7F, 8'h04); wr(8'hF2, 8'h99); rd(8'hF2, 8'h00, "R5 vendor pw");
    wr(8'h7B, 8'h00);                       // user level (user pw 0)
    wr(8'hF0, 8'h04); wr(8'hF1, 8'h24);     // block2 rd/wr, block5 wr need vendor
    wr(8'h7F, 8'h01); wr(8'h90, 8'h5A);
    rd(8'h90, 8'h00, "R8 user denied vendor block");
    wr(8'h7F, 8'h04); wr(8'hF1, 8'h00);     // denied
    wr(8'h7F, 8'h05); wr(8'hE0, 8'h01); wr(8'hE1, 8'h01);
    rd(8'hE0, 8'h00, "R5 user settings");
    wr(8'hE2, 8'h42);                       // level none
    wr(8'h10, 8'hFF);
    rd(8'h10, 8'h00, "R8 none denied block0");
    wr(8'h79, 8'h66); rd(8'h79, 8'h66, "R9 window");
    rd(8'h7F, 8'h05, "R9 select at none");
    wr(8'h7B, 8'h42);
    rd(8'h10, 8'hA5, "R11 next-cycle unlock, R10 write dropped");
    wr(8'h7B, 8'h99);                       // vendor
    wr(8'h7F, 8'h01);
    rd(8'h90, 8'h00, "R10 earlier write dropped");
    wr(8'h90, 8'h5A); rd(8'h90, 8'h5A, "R7 vendor full access");
    // layout bit
    wr(8'h7F, 8'h04); wr(8'h80, 8'h01);
    wr(8'h7F, 8'h00); rd(8'h90, 8'h5A, "R6 sel0 to table1");
    wr(8'h7F, 8'h01); rd(8'h80, 8'h01, "R6 sel1 to table4");
    wr(8'h7F, 8'h04); rd(8'h80, 8'h00, "R6 sel4 invalid");
    wr(8'h7B, 8'h00);                       // none
    wr(8'h7F, 8'h00);
    rd(8'h90, 8'h00, "R8 none vendor block");
    rd(8'h10, 8'h00, "R8 none user block");
    wr(8'h7B, 8'h42);                       // user
    rd(8'h90, 8'h00, "R8 user vendor block");
    rd(8'h10, 8'hA5, "R8 user block0");
    idle();
    repeat (3) @(negedge clk);
    check("R2 all reads answered", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule